// File: doc/BRIEF.md
# Pipelined 16-bit Floating-Point Add/Subtract/Multiply Unit

This unit takes two 16-bit floating-point operands and an operation code. It returns their sum, difference or product in the same 16-bit format. Each word has a sign in bit 15, a 5-bit exponent in bits 14:10 stored with an offset of 31, and a 10-bit fraction in bits 9:0. A nonzero word has the value (-1)^sign × 1.fraction × 2^(exponent − 31), with the leading one implied. The largest exponent code is therefore 31, and every finite value lies below 2.0 in magnitude.

The unit is fully pipelined and accepts a new operation on every clock. It has three register stages. The first aligns the operands and adds them, or multiplies them. The second normalizes the raw result. The third rounds it, packs it and sets the status bits. Infinities, NaNs, denormals and division are not part of this format. A result whose exponent is too large is clamped to the largest finite magnitude and flagged. A result whose exponent is too small becomes zero and is flagged.

Top module: `fpb_unit`

## Requirements
- R1: A word with a nonzero exponent field encodes (-1)^bit15 × 1.bits[9:0] × 2^(bits[14:10] − 31), so 1.0 is 0x7C00 and 0.5 is 0x7800.
- R2: out_valid is high exactly three rising clock edges after the edge that samples in_valid high, and is low otherwise.
- R3: in_op 2'b00 selects a+b, 2'b01 selects a−b, and 2'b10 or 2'b11 selects a×b (in_op[0] is ignored for multiply).
- R4: A word whose exponent field is 0 is zero, whatever its fraction bits hold. An exactly zero result is returned as 0x0000 with both status bits low.
- R5: An add or subtract aligns the smaller magnitude to the larger one. When a subtraction cancels leading bits, the result is shifted left and its exponent lowered until the implied one returns.
- R6: Rounding is to nearest, with an exact halfway case going to the even fraction.
- R7: When rounding carries out of the fraction, the fraction becomes 0 and the exponent rises by one.
- R8: A rounded exponent above 31 gives the word {sign, 15'h7FFF} with out_ovf high.
- R9: A rounded exponent below 1 gives 0x0000 with out_unf high. out_ovf and out_unf are never high together.
- R10: A product has the XOR of the operand signs. Its exponent before normalization is the sum of the stored exponents minus 31.
- R11: While rst_n is low, out_valid, out_res, out_ovf and out_unf are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| in_op | input | 2 | Operation: 00 add, 01 subtract, 1x multiply |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| out_valid | output | 1 | Result word and status bits are valid |
| out_res | output | 16 | Result word |
| out_ovf | output | 1 | Result exponent too large; magnitude clamped |
| out_unf | output | 1 | Result exponent too small; flushed to zero |

## Verification
Every result appears at the ports three rising edges after the edge that sampled its inputs. The bench drives inputs on the falling edge and reads the result on the third falling edge after that. On the falling edge just before that one, it confirms that out_valid is still low. A back-to-back pair confirms that consecutive operations come out on consecutive cycles and that out_valid drops on the cycle after them. Reset values are read while reset is still held, before any input has been applied.

// File: rtl/fpb_pkg.sv
`timescale 1ns/1ps
package fpb_pkg;
  localparam int EW   = 5;                 // exponent field width
  localparam int MW   = 10;                // fraction field width
  localparam int WW   = 1 + EW + MW;       // word width
  localparam int BIAS = 31;                // exponent offset
  localparam int SW   = MW + 1;            // significand with implied one
  localparam int XW   = SW + 3;            // significand plus guard/round/sticky
  localparam int RW   = 2 * SW + 1;        // raw result width
  localparam int ONE_POS = 2 * SW - 1;     // raw bit weighted 2^0
  localparam int EXW  = EW + 5;            // signed working exponent width
  localparam int SHW  = 1 << EW;           // widest alignment shift

  localparam logic signed [EXW-1:0] BIAS_X  = EXW'(BIAS);
  localparam logic signed [EXW-1:0] EXP_TOP = EXW'((1 << EW) - 1);
  localparam logic signed [EXW-1:0] EXP_LOW = EXW'(1);

  typedef struct packed {
    logic                  sign;
    logic                  zero;
    logic signed [EXW-1:0] exp;
    logic [RW-1:0]         raw;
    logic                  sticky;
  } raw_t;

  typedef struct packed {
    logic                  sign;
    logic                  zero;
    logic signed [EXW-1:0] exp;
    logic [XW-1:0]         sig;
    logic                  sticky;
  } norm_t;

  typedef struct packed {
    logic          ovf;
    logic          unf;
    logic          rup;
    logic          mcarry;
    logic [WW-1:0] word;
  } res_t;

  function automatic logic [SW-1:0] sig_of(input logic [WW-1:0] w);
    return (w[WW-2:MW] == '0) ? '0 : {1'b1, w[MW-1:0]};
  endfunction

  function automatic logic [WW-2:0] mag_of(input logic [WW-1:0] w);
    return (w[WW-2:MW] == '0) ? '0 : w[WW-2:0];
  endfunction

  // Stage 1: aligned add/subtract or full product, unnormalized
  function automatic raw_t front_calc(input logic [WW-1:0] a, input logic [WW-1:0] b,
                                      input logic [1:0] op);
    raw_t r;
    logic [WW-1:0] bx, big, sml;
    logic [XW-1:0] xa, xb;
    logic [XW+SHW-1:0] ext;
    logic [EW-1:0] d;
    logic [XW:0] sum;
    logic [2*SW-1:0] prod;
    r = '0;
    if (op[1]) begin
      prod   = (2*SW)'(sig_of(a)) * (2*SW)'(sig_of(b));
      r.sign = a[WW-1] ^ b[WW-1];
      r.exp  = $signed({{(EXW-EW){1'b0}}, a[WW-2:MW]}) +
               $signed({{(EXW-EW){1'b0}}, b[WW-2:MW]}) - BIAS_X;
      r.raw  = {prod, 1'b0};
    end else begin
      bx = {b[WW-1] ^ op[0], b[WW-2:0]};
      if (mag_of(bx) > mag_of(a)) begin big = bx; sml = a; end
      else begin big = a; sml = bx; end
      xa    = {sig_of(big), 3'b000};
      xb    = {sig_of(sml), 3'b000};
      d     = big[WW-2:MW] - sml[WW-2:MW];
      ext   = {xb, {SHW{1'b0}}} >> d;
      xb    = ext[XW+SHW-1:SHW];
      xb[0] = xb[0] | (|ext[SHW-1:0]);
      sum   = (big[WW-1] ^ sml[WW-1]) ? ({1'b0, xa} - {1'b0, xb})
                                      : ({1'b0, xa} + {1'b0, xb});
      r.sign = big[WW-1];
      r.exp  = $signed({{(EXW-EW){1'b0}}, big[WW-2:MW]});
      r.raw  = {sum, {(RW-XW-1){1'b0}}};
    end
    r.zero = (r.raw == '0);
    return r;
  endfunction

  // Stage 2: bring the leading one to the top of the significand
  function automatic norm_t norm_calc(input raw_t r);
    norm_t n;
    logic [RW-1:0] sh;
    int lp;
    lp = 0;
    for (int i = 0; i < RW; i++) if (r.raw[i]) lp = i;
    sh       = r.raw << (RW - 1 - lp);
    n.sign   = r.sign;
    n.zero   = r.zero;
    n.exp    = r.exp + EXW'(lp - ONE_POS);
    n.sig    = sh[RW-1 -: XW];
    n.sticky = r.sticky | (|sh[RW-XW-1:0]);
    return n;
  endfunction

  // Stage 3: round to nearest even, range check, pack
  function automatic res_t pack_calc(input norm_t n);
    res_t q;
    logic [SW:0] rm;
    logic st;
    logic signed [EXW-1:0] e;
    q        = '0;
    st       = n.sticky | (|n.sig[1:0]);
    q.rup    = n.sig[2] & (st | n.sig[3]);
    rm       = {1'b0, n.sig[XW-1:3]} + {{SW{1'b0}}, q.rup};
    q.mcarry = rm[SW];
    e        = n.exp + {{(EXW-1){1'b0}}, rm[SW]};
    if (n.zero) q = '0;
    else if (e > EXP_TOP) begin q.ovf = 1'b1; q.word = {n.sign, {(WW-1){1'b1}}}; end
    else if (e < EXP_LOW) begin q.unf = 1'b1; q.word = '0; end
    else q.word = {n.sign, e[EW-1:0], rm[MW-1:0]};
    return q;
  endfunction
endpackage

// File: rtl/fpb_front.sv
`timescale 1ns/1ps
module fpb_front
  import fpb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic [WW-1:0] in_a,
  input  logic [WW-1:0] in_b,
  output logic          out_valid,
  output raw_t          out_raw
);
  logic is_mul;
  raw_t raw_d;
  assign is_mul = in_op[1];
  assign raw_d  = front_calc(in_a, in_b, in_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_raw   <= '0;
    end else begin
      out_valid <= in_valid;
      out_raw   <= raw_d;
    end
  end

  // R10: product sign follows the operand signs one stage later
  p_mul_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_mul) |=> (out_raw.sign == ($past(in_a[WW-1]) ^ $past(in_b[WW-1]))));
endmodule

// File: rtl/fpb_norm.sv
`timescale 1ns/1ps
module fpb_norm
  import fpb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  raw_t  in_raw,
  output logic  out_valid,
  output norm_t out_norm
);
  norm_t norm_d;
  logic  lead_ok;
  assign norm_d  = norm_calc(in_raw);
  assign lead_ok = out_norm.sig[XW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_norm  <= '0;
    end else begin
      out_valid <= in_valid;
      out_norm  <= norm_d;
    end
  end

  // R5: every nonzero normalized significand carries its implied one on top
  p_norm_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_norm.zero) |-> lead_ok);
endmodule

// File: rtl/fpb_round.sv
`timescale 1ns/1ps
module fpb_round
  import fpb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  norm_t         in_norm,
  output logic          out_valid,
  output logic [WW-1:0] out_word,
  output logic          out_ovf,
  output logic          out_unf
);
  res_t res_d;
  logic round_up, mant_carry, ovf_hit, unf_hit;
  assign res_d      = pack_calc(in_norm);
  assign round_up   = res_d.rup;
  assign mant_carry = res_d.mcarry;
  assign ovf_hit    = res_d.ovf;
  assign unf_hit    = res_d.unf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_ovf   <= 1'b0;
      out_unf   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_word  <= res_d.word;
      out_ovf   <= ovf_hit;
      out_unf   <= unf_hit;
    end
  end

  // R4: a zero intermediate leaves a clean zero with no status
  p_zero_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_norm.zero) |=> (out_word == '0 && !out_ovf && !out_unf));
  // R7: a fraction carry that stays in range leaves a zero fraction
  p_carry_frac_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_norm.zero && mant_carry && round_up && !ovf_hit && !unf_hit)
      |=> (out_word[MW-1:0] == '0));
endmodule

// File: rtl/fpb_unit.sv
`timescale 1ns/1ps
module fpb_unit
  import fpb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic [WW-1:0] in_a,
  input  logic [WW-1:0] in_b,
  output logic          out_valid,
  output logic [WW-1:0] out_res,
  output logic          out_ovf,
  output logic          out_unf
);
  logic  s1_valid, s2_valid;
  raw_t  s1_raw;
  norm_t s2_norm;

  fpb_front u_front (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(s1_valid), .out_raw(s1_raw)
  );

  fpb_norm u_norm (
    .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .in_raw(s1_raw),
    .out_valid(s2_valid), .out_norm(s2_norm)
  );

  fpb_round u_round (
    .clk(clk), .rst_n(rst_n), .in_valid(s2_valid), .in_norm(s2_norm),
    .out_valid(out_valid), .out_word(out_res), .out_ovf(out_ovf), .out_unf(out_unf)
  );

  // R2: a result only ever follows an accepted operation by three edges
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));
  // R8: clamped results carry the largest finite magnitude
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_res[WW-2:0] == '1));
  // R9: flushed results are plain zero
  p_flush_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unf) |-> (out_res == '0));
  // R9: the two status bits exclude each other
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_ovf && out_unf));
endmodule

// File: tb/fpb_unit_test.sv
`timescale 1ns/1ps
module fpb_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic [15:0] in_a = '0, in_b = '0;
  logic        out_valid, out_ovf, out_unf;
  logic [15:0] out_res;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpb_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_res(out_res),
    .out_ovf(out_ovf), .out_unf(out_unf)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic [1:0]  op;
    logic [15:0] a, b, res;
    logic        ovf, unf;
  } vec_t;

  // op: 00 add, 01 sub, 1x mul. 1.0=7C00, 0.5=7800, 1.5=7E00, 0.75=7A00, 0.25=7400
  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  2'b00, 16'h7800, 16'h7800, 16'h7C00, 1'b0, 1'b0}, // R1 0.5+0.5
    '{4'd8,  2'b00, 16'h7C00, 16'h7C00, 16'h7FFF, 1'b1, 1'b0}, // R8 1+1 clamps
    '{4'd3,  2'b01, 16'h7E00, 16'h7800, 16'h7C00, 1'b0, 1'b0}, // R3 1.5-0.5
    '{4'd5,  2'b01, 16'h7800, 16'h7A00, 16'hF400, 1'b0, 1'b0}, // R5 0.5-0.75
    '{4'd8,  2'b10, 16'h7E00, 16'h7E00, 16'h7FFF, 1'b1, 1'b0}, // R8 1.5*1.5
    '{4'd10, 2'b10, 16'h7800, 16'h7800, 16'h7400, 1'b0, 1'b0}, // R10 0.5*0.5
    '{4'd10, 2'b10, 16'h7E00, 16'h7A00, 16'h7C80, 1'b0, 1'b0}, // R10 1.5*0.75
    '{4'd4,  2'b01, 16'h7E00, 16'h7E00, 16'h0000, 1'b0, 1'b0}, // R4 x-x
    '{4'd4,  2'b00, 16'h0000, 16'h7A00, 16'h7A00, 1'b0, 1'b0}, // R4 0+x
    '{4'd4,  2'b10, 16'h0155, 16'h7C00, 16'h0000, 1'b0, 1'b0}, // R4 zero exp, junk fraction
    '{4'd9,  2'b10, 16'h0400, 16'h0400, 16'h0000, 1'b0, 1'b1}, // R9 tiny*tiny
    '{4'd6,  2'b00, 16'h7C00, 16'h5000, 16'h7C00, 1'b0, 1'b0}, // R6 tie, stays even
    '{4'd6,  2'b00, 16'h7C01, 16'h5000, 16'h7C02, 1'b0, 1'b0}, // R6 tie, odd goes up
    '{4'd6,  2'b00, 16'h7C00, 16'h5001, 16'h7C01, 1'b0, 1'b0}, // R6 above half
    '{4'd7,  2'b00, 16'h7BFF, 16'h4C00, 16'h7C00, 1'b0, 1'b0}, // R7 carry into exponent
    '{4'd8,  2'b00, 16'h7FFF, 16'h5000, 16'h7FFF, 1'b1, 1'b0}, // R8 rounding overflows
    '{4'd5,  2'b01, 16'h7C00, 16'h5000, 16'h7BFF, 1'b0, 1'b0}, // R5 cancel and renormalize
    '{4'd3,  2'b11, 16'h7800, 16'h7800, 16'h7400, 1'b0, 1'b0}, // R3 op 11 multiplies
    '{4'd10, 2'b10, 16'hF800, 16'h7800, 16'hF400, 1'b0, 1'b0}, // R10 sign XOR
    '{4'd3,  2'b01, 16'h7800, 16'hF800, 16'h7C00, 1'b0, 1'b0}, // R3 minus a negative
    '{4'd8,  2'b00, 16'hFC00, 16'hFC00, 16'hFFFF, 1'b1, 1'b0}, // R8 negative clamp
    '{4'd6,  2'b10, 16'h7E00, 16'h7C01, 16'h7E02, 1'b0, 1'b0}, // R6 product tie to even
    '{4'd9,  2'b01, 16'h0401, 16'h0400, 16'h0000, 1'b0, 1'b1}  // R9 cancel below range
  };

  task automatic check_res(input int tag, input logic [15:0] er, input logic eo, input logic eu);
    n_chk++;
    if (!(out_valid === 1'b1 && out_res === er && out_ovf === eo && out_unf === eu)) begin
      n_bad++;
      $display("FAIL R%0d: got valid=%b res=%h ovf=%b unf=%b, expected valid=1 res=%h ovf=%b unf=%b",
               tag, out_valid, out_res, out_ovf, out_unf, er, eo, eu);
    end
  endtask

  task automatic check_valid(input int tag, input logic ev);
    n_chk++;
    if (out_valid !== ev) begin
      n_bad++;
      $display("FAIL R%0d: got out_valid=%b, expected %b", tag, out_valid, ev);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R11: reset values while reset is held
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_res !== 16'h0 || out_ovf !== 1'b0 || out_unf !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: got valid=%b res=%h ovf=%b unf=%b, expected all zero",
               out_valid, out_res, out_ovf, out_unf);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: drive, drop valid, confirm not early (R2), then check result
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].a, VEC[i].b);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check_valid(2, 1'b0); // R2 not yet after two edges
      @(negedge clk);
      check_res(int'(VEC[i].tag), VEC[i].res, VEC[i].ovf, VEC[i].unf);
    end

    // R2: back-to-back operations emerge on consecutive cycles, then valid drops
    @(negedge clk);
    drive(2'b00, 16'h7800, 16'h7800);
    @(negedge clk);
    drive(2'b10, 16'h7E00, 16'h7A00);
    @(negedge clk);
    in_valid = 1'b0;
    in_a = 16'h7C00; in_b = 16'h7C00; // not valid, must not appear
    @(negedge clk);
    check_res(2, 16'h7C00, 1'b0, 1'b0);
    @(negedge clk);
    check_res(2, 16'h7C80, 1'b0, 1'b0);
    @(negedge clk);
    check_valid(2, 1'b0);
    @(negedge clk);
    check_valid(2, 1'b0);

    // R3: op 01 with equal operands is a true subtraction giving zero (R4 encoding)
    drive(2'b01, 16'h7C00, 16'h7C00);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check_res(3, 16'h0000, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule